// File: doc/BRIEF.md
# Pipeline Data-Hazard Resolver

This block resolves read-after-write register hazards in a five-stage in-order pipeline where every register write lands in the fifth stage. Write-after-write and write-after-read conflicts cannot arise there, because all writes happen in the last stage in issue order. The block is purely combinational. It looks at the operation class, destination and source register numbers, and immediate flag of the instructions in stages 2 to 5. It also sees the results held at the outputs of stages 4 and 5.

For an ALU instruction in stage 3, the block picks each ALU operand from one of three places: the value latched in the stage-3 pipeline register, the stage-4 result, or the stage-5 result. It drives both the select codes and the chosen operand values. A loaded value cannot reach the instruction that directly follows the load, so that case cannot be forwarded. When an ALU instruction in stage 2 needs the destination of a load in stage 3, the block holds the stage-1 and stage-2 registers for one cycle and asks for a bubble to be put into stage 3.

Top module: `hazard_resolver`

## Requirements
- R1: When no forwarding condition holds, both selects are 0 (pipeline register) and the ALU operand outputs equal the stage-3 latched operands, with no stall signalled.
- R2: With an ALU-class instruction (class code 1) in stage 3, when the stage-4 destination equals the first source and the stage-4 class is ALU (1), load-address (3) or branch-and-link (6), the X select is 1 and the X operand equals the stage-4 result.
- R3: With an ALU instruction in stage 3 and no stage-4 match, when the stage-5 destination equals the first source and the stage-5 class writes a register (ALU 1, load 2, load-address 3, branch-and-link 6), the X select is 2 and the X operand equals the stage-5 result.
- R4: When stage 4 and stage 5 both match the same source, the stage-4 result is chosen (select 1).
- R5: The second source is forwarded by the same rules onto Y. When the stage-3 immediate flag is 1, the Y select stays 0 and Y equals the latched operand.
- R6: A load (class 2) in stage 4 never forwards its stage-4 value, which is only an address.
- R7: No forwarding happens when the stage-3 class is not ALU, or when the matching producer is nop (0), store (4) or branch (5).
- R8: With a load (class 2) in stage 3 and an ALU instruction in stage 2, a match of the load destination against the stage-2 first source, or against the stage-2 second source when that instruction is not immediate, raises the stage-1 hold, the stage-2 hold and the stage-3 bubble request together.
- R9: No stall is raised when the stage-3 class is not load, when the stage-2 class is not ALU, or when only the second source matches and the stage-2 immediate flag is 1.
- R10: Register number 0 is handled like any other register for both forwarding and stalling.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cls_s2 | input | 3 | Operation class in stage 2 |
| src_b_s2 | input | REG_AW | First source register, stage 2 |
| src_c_s2 | input | REG_AW | Second source register, stage 2 |
| imm_s2 | input | 1 | Stage-2 instruction uses an immediate second operand |
| cls_s3 | input | 3 | Operation class in stage 3 |
| dst_s3 | input | REG_AW | Destination register, stage 3 |
| src_b_s3 | input | REG_AW | First source register, stage 3 |
| src_c_s3 | input | REG_AW | Second source register, stage 3 |
| imm_s3 | input | 1 | Stage-3 instruction uses an immediate second operand |
| opnd_x_s3 | input | DATA_W | Latched first ALU operand |
| opnd_y_s3 | input | DATA_W | Latched second ALU operand |
| cls_s4 | input | 3 | Operation class in stage 4 |
| dst_s4 | input | REG_AW | Destination register, stage 4 |
| res_s4 | input | DATA_W | Stage-4 result value |
| cls_s5 | input | 3 | Operation class in stage 5 |
| dst_s5 | input | REG_AW | Destination register, stage 5 |
| res_s5 | input | DATA_W | Stage-5 result value |
| sel_x | output | 2 | X source: 0 latched, 1 stage 4, 2 stage 5 |
| sel_y | output | 2 | Y source, same coding |
| alu_x | output | DATA_W | Chosen first ALU operand |
| alu_y | output | DATA_W | Chosen second ALU operand |
| hold_fetch | output | 1 | Hold stage-1 registers |
| hold_decode | output | 1 | Hold stage-2 registers |
| bubble_s3 | output | 1 | Force a nop into stage 3 |

## Verification
A wrong match or priority decision shows up at once on the select codes and the operand outputs, in the same evaluation as the offending input pattern. A wrong stall decision shows on the three stall outputs, also with no delay. The bench therefore drives one pipeline snapshot at a time. It checks every output against a model built from the requirements. It uses a small register range so that matches, double matches and load-use cases occur often.

// File: rtl/hz_pkg.sv
package hz_pkg;

   typedef enum logic [2:0] {
      CLS_NOP    = 3'd0,
      CLS_ALU    = 3'd1,
      CLS_LOAD   = 3'd2,
      CLS_LADR   = 3'd3,
      CLS_STORE  = 3'd4,
      CLS_BRANCH = 3'd5,
      CLS_BRL    = 3'd6
   } op_class_e;

   typedef enum logic [1:0] {
      SEL_PIPE = 2'd0,
      SEL_S4   = 2'd1,
      SEL_S5   = 2'd2
   } fwd_sel_e;

   // result already final at the end of stage 3 (loads still carry an address)
   function automatic logic ready_at_s4(op_class_e c);
      return (c == CLS_ALU) || (c == CLS_LADR) || (c == CLS_BRL);
   endfunction

   function automatic logic writes_reg(op_class_e c);
      return (c == CLS_ALU) || (c == CLS_LOAD) || (c == CLS_LADR) || (c == CLS_BRL);
   endfunction

endpackage

// File: rtl/hz_src_match.sv
module hz_src_match
   import hz_pkg::*;
#(
   parameter int REG_AW = 5
) (
   input  logic [REG_AW-1:0] src,
   input  logic              src_used,
   input  op_class_e         cls_s4,
   input  logic [REG_AW-1:0] dst_s4,
   input  op_class_e         cls_s5,
   input  logic [REG_AW-1:0] dst_s5,
   output fwd_sel_e          sel
);

   logic hit_s4;
   logic hit_s5;

   assign hit_s4 = src_used && ready_at_s4(cls_s4) && (dst_s4 == src);
   assign hit_s5 = src_used && writes_reg(cls_s5) && (dst_s5 == src);

   // younger stage wins
   always_comb begin
      if (hit_s4)      sel = SEL_S4;
      else if (hit_s5) sel = SEL_S5;
      else             sel = SEL_PIPE;
   end

endmodule

// File: rtl/hz_opnd_mux.sv
module hz_opnd_mux
   import hz_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  fwd_sel_e          sel,
   input  logic [DATA_W-1:0] latched,
   input  logic [DATA_W-1:0] from_s4,
   input  logic [DATA_W-1:0] from_s5,
   output logic [DATA_W-1:0] opnd
);

   always_comb begin
      unique case (sel)
         SEL_S4:  opnd = from_s4;
         SEL_S5:  opnd = from_s5;
         default: opnd = latched;
      endcase
   end

endmodule

// File: rtl/hz_load_use.sv
module hz_load_use
   import hz_pkg::*;
#(
   parameter int REG_AW = 5
) (
   input  op_class_e         cls_s2,
   input  logic [REG_AW-1:0] src_b_s2,
   input  logic [REG_AW-1:0] src_c_s2,
   input  logic              imm_s2,
   input  op_class_e         cls_s3,
   input  logic [REG_AW-1:0] dst_s3,
   output logic              stall
);

   logic need_b;
   logic need_c;

   assign need_b = (dst_s3 == src_b_s2);
   assign need_c = !imm_s2 && (dst_s3 == src_c_s2);
   assign stall  = (cls_s3 == CLS_LOAD) && (cls_s2 == CLS_ALU) && (need_b || need_c);

endmodule

// File: rtl/hazard_resolver.sv
module hazard_resolver
   import hz_pkg::*;
#(
   parameter int REG_AW = 5,
   parameter int DATA_W = 32
) (
   input  logic [2:0]        cls_s2,
   input  logic [REG_AW-1:0] src_b_s2,
   input  logic [REG_AW-1:0] src_c_s2,
   input  logic              imm_s2,
   input  logic [2:0]        cls_s3,
   input  logic [REG_AW-1:0] dst_s3,
   input  logic [REG_AW-1:0] src_b_s3,
   input  logic [REG_AW-1:0] src_c_s3,
   input  logic              imm_s3,
   input  logic [DATA_W-1:0] opnd_x_s3,
   input  logic [DATA_W-1:0] opnd_y_s3,
   input  logic [2:0]        cls_s4,
   input  logic [REG_AW-1:0] dst_s4,
   input  logic [DATA_W-1:0] res_s4,
   input  logic [2:0]        cls_s5,
   input  logic [REG_AW-1:0] dst_s5,
   input  logic [DATA_W-1:0] res_s5,
   output logic [1:0]        sel_x,
   output logic [1:0]        sel_y,
   output logic [DATA_W-1:0] alu_x,
   output logic [DATA_W-1:0] alu_y,
   output logic              hold_fetch,
   output logic              hold_decode,
   output logic              bubble_s3
);

   localparam int N_OPND = 2;

   if (REG_AW < 1 || REG_AW > 8) begin : g_bad_aw
      $error("hazard_resolver: REG_AW out of range");
   end
   if (DATA_W < 1) begin : g_bad_dw
      $error("hazard_resolver: DATA_W must be positive");
   end

   op_class_e c2, c3, c4, c5;
   assign c2 = op_class_e'(cls_s2);
   assign c3 = op_class_e'(cls_s3);
   assign c4 = op_class_e'(cls_s4);
   assign c5 = op_class_e'(cls_s5);

   logic [REG_AW-1:0] src_arr  [N_OPND];
   logic              used_arr [N_OPND];
   logic [DATA_W-1:0] lat_arr  [N_OPND];
   logic [DATA_W-1:0] out_arr  [N_OPND];
   fwd_sel_e          sel_arr  [N_OPND];

   assign src_arr[0]  = src_b_s3;
   assign src_arr[1]  = src_c_s3;
   assign used_arr[0] = (c3 == CLS_ALU);
   assign used_arr[1] = (c3 == CLS_ALU) && !imm_s3;
   assign lat_arr[0]  = opnd_x_s3;
   assign lat_arr[1]  = opnd_y_s3;

   for (genvar i = 0; i < N_OPND; i++) begin : g_opnd
      hz_src_match #(.REG_AW(REG_AW)) i_match (
         .src      (src_arr[i]),
         .src_used (used_arr[i]),
         .cls_s4   (c4),
         .dst_s4   (dst_s4),
         .cls_s5   (c5),
         .dst_s5   (dst_s5),
         .sel      (sel_arr[i])
      );
      hz_opnd_mux #(.DATA_W(DATA_W)) i_mux (
         .sel     (sel_arr[i]),
         .latched (lat_arr[i]),
         .from_s4 (res_s4),
         .from_s5 (res_s5),
         .opnd    (out_arr[i])
      );
   end

   assign sel_x = sel_arr[0];
   assign sel_y = sel_arr[1];
   assign alu_x = out_arr[0];
   assign alu_y = out_arr[1];

   logic stall;

   hz_load_use #(.REG_AW(REG_AW)) i_load_use (
      .cls_s2   (c2),
      .src_b_s2 (src_b_s2),
      .src_c_s2 (src_c_s2),
      .imm_s2   (imm_s2),
      .cls_s3   (c3),
      .dst_s3   (dst_s3),
      .stall    (stall)
   );

   assign hold_fetch  = stall;
   assign hold_decode = stall;
   assign bubble_s3   = stall;

   always_comb begin
      // R2
      if (sel_x == 2'd1)
         fwd_x_s4_chk: assert (dst_s4 == src_b_s3 && ready_at_s4(c4) && alu_x == res_s4)
            else $error("X stage-4 forward without a valid producer");
      // R4
      if (sel_x == 2'd2)
         prio_x_chk: assert (!(ready_at_s4(c4) && dst_s4 == src_b_s3) && alu_x == res_s5)
            else $error("stage-5 chosen over a matching stage-4 producer");
      // R5
      if (imm_s3)
         imm_y_chk: assert (sel_y == 2'd0 && alu_y == opnd_y_s3)
            else $error("immediate operand was forwarded");
      // R7
      if (c3 != CLS_ALU)
         non_alu_chk: assert (sel_x == 2'd0 && sel_y == 2'd0)
            else $error("forward for a non-ALU consumer");
      // R8
      if (bubble_s3)
         stall_load_chk: assert (hold_fetch && hold_decode && c3 == CLS_LOAD && c2 == CLS_ALU)
            else $error("stall without a load-use pair");
   end

endmodule

// File: tb/test_hazard_resolver.sv
module test_hazard_resolver;

   localparam int AW = 5;
   localparam int DW = 32;

   logic          clk = 1'b0;
   logic [2:0]    cls_s2, cls_s3, cls_s4, cls_s5;
   logic [AW-1:0] src_b_s2, src_c_s2, dst_s3, src_b_s3, src_c_s3, dst_s4, dst_s5;
   logic          imm_s2, imm_s3;
   logic [DW-1:0] opnd_x_s3, opnd_y_s3, res_s4, res_s5;
   logic [1:0]    sel_x, sel_y;
   logic [DW-1:0] alu_x, alu_y;
   logic          hold_fetch, hold_decode, bubble_s3;

   int checks = 0;
   int errors = 0;
   bit done   = 0;

   always #2 clk = ~clk;

   hazard_resolver #(.REG_AW(AW), .DATA_W(DW)) i_hazard_resolver (.*);

   function automatic logic [1:0] ref_sel(logic used, logic [AW-1:0] src);
      logic ok4, ok5;
      ok4 = (cls_s4 == 3'd1) || (cls_s4 == 3'd3) || (cls_s4 == 3'd6);
      ok5 = (cls_s5 == 3'd1) || (cls_s5 == 3'd2) || (cls_s5 == 3'd3) || (cls_s5 == 3'd6);
      if (!used) return 2'd0;
      if (ok4 && dst_s4 == src) return 2'd1;
      if (ok5 && dst_s5 == src) return 2'd2;
      return 2'd0;
   endfunction

   function automatic logic ref_stall();
      return (cls_s3 == 3'd2) && (cls_s2 == 3'd1) &&
             ((dst_s3 == src_b_s2) || (!imm_s2 && dst_s3 == src_c_s2));
   endfunction

   function automatic logic [DW-1:0] pick(logic [1:0] s, logic [DW-1:0] lat);
      return (s == 2'd1) ? res_s4 : (s == 2'd2) ? res_s5 : lat;
   endfunction

   task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic clear();
      cls_s2 = 0; cls_s3 = 0; cls_s4 = 0; cls_s5 = 0;
      src_b_s2 = 1; src_c_s2 = 2; imm_s2 = 0;
      dst_s3 = 3; src_b_s3 = 4; src_c_s3 = 5; imm_s3 = 0;
      dst_s4 = 6; dst_s5 = 7;
      opnd_x_s3 = 32'h1111_0001; opnd_y_s3 = 32'h2222_0002;
      res_s4 = 32'h4444_0004; res_s5 = 32'h5555_0005;
   endtask

   task automatic settle();
      @(negedge clk);
      #1;
   endtask

   task automatic chk_all(string req);
      logic [1:0] ex, ey;
      logic       st;
      ex = ref_sel(cls_s3 == 3'd1, src_b_s3);
      ey = ref_sel(cls_s3 == 3'd1 && !imm_s3, src_c_s3);
      st = ref_stall();
      chk(req, "sel_x", sel_x, ex);
      chk(req, "sel_y", sel_y, ey);
      chk(req, "alu_x", alu_x, pick(ex, opnd_x_s3));
      chk(req, "alu_y", alu_y, pick(ey, opnd_y_s3));
      chk(req, "stall", {hold_fetch, hold_decode, bubble_s3}, {3{st}});
   endtask

   initial begin
      #(4 * 200000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd1234));
      clear();
      settle();
      // R1 idle pipeline
      chk("R1", "sel_x", sel_x, 2'd0);
      chk("R1", "alu_y", alu_y, opnd_y_s3);
      chk("R1", "stall", {hold_fetch, hold_decode, bubble_s3}, 3'b000);

      // R2 ALU in stage 4 feeds X
      clear(); cls_s3 = 1; cls_s4 = 1; dst_s4 = 4; settle();
      chk("R2", "sel_x", sel_x, 2'd1);
      chk("R2", "alu_x", alu_x, res_s4);

      // R3 load in stage 5 feeds X
      clear(); cls_s3 = 1; cls_s5 = 2; dst_s5 = 4; settle();
      chk("R3", "sel_x", sel_x, 2'd2);
      chk("R3", "alu_x", alu_x, res_s5);

      // R4 both stages match
      clear(); cls_s3 = 1; cls_s4 = 6; dst_s4 = 5; cls_s5 = 1; dst_s5 = 5; settle();
      chk("R4", "sel_y", sel_y, 2'd1);
      chk("R4", "alu_y", alu_y, res_s4);

      // R5 immediate form leaves Y alone
      clear(); cls_s3 = 1; imm_s3 = 1; cls_s4 = 1; dst_s4 = 5; settle();
      chk("R5", "sel_y", sel_y, 2'd0);
      chk("R5", "alu_y", alu_y, opnd_y_s3);
      clear(); cls_s3 = 1; cls_s5 = 3; dst_s5 = 5; settle();
      chk("R5", "sel_y", sel_y, 2'd2);

      // R6 load in stage 4 is not forwarded; stage 5 is used instead
      clear(); cls_s3 = 1; cls_s4 = 2; dst_s4 = 4; cls_s5 = 1; dst_s5 = 4; settle();
      chk("R6", "sel_x", sel_x, 2'd2);
      clear(); cls_s3 = 1; cls_s4 = 2; dst_s4 = 4; settle();
      chk("R6", "alu_x", alu_x, opnd_x_s3);

      // R7 non-ALU consumer, store and branch producers
      clear(); cls_s3 = 4; cls_s4 = 1; dst_s4 = 4; settle();
      chk("R7", "sel_x", sel_x, 2'd0);
      clear(); cls_s3 = 1; cls_s4 = 4; dst_s4 = 4; cls_s5 = 5; dst_s5 = 5; settle();
      chk("R7", "sels", {sel_x, sel_y}, 4'b0000);

      // R8 load-use on either source
      clear(); cls_s3 = 2; cls_s2 = 1; dst_s3 = 1; settle();
      chk("R8", "stall", {hold_fetch, hold_decode, bubble_s3}, 3'b111);
      clear(); cls_s3 = 2; cls_s2 = 1; dst_s3 = 2; settle();
      chk("R8", "stall", {hold_fetch, hold_decode, bubble_s3}, 3'b111);

      // R9 no stall cases
      clear(); cls_s3 = 2; cls_s2 = 1; dst_s3 = 2; imm_s2 = 1; settle();
      chk("R9", "stall", {hold_fetch, hold_decode, bubble_s3}, 3'b000);
      clear(); cls_s3 = 1; cls_s2 = 1; dst_s3 = 1; settle();
      chk("R9", "stall", {hold_fetch, hold_decode, bubble_s3}, 3'b000);
      clear(); cls_s3 = 2; cls_s2 = 4; dst_s3 = 1; settle();
      chk("R9", "stall", {hold_fetch, hold_decode, bubble_s3}, 3'b000);

      // R10 register 0
      clear(); cls_s3 = 1; src_b_s3 = 0; cls_s4 = 3; dst_s4 = 0; settle();
      chk("R10", "sel_x", sel_x, 2'd1);
      clear(); cls_s3 = 2; dst_s3 = 0; cls_s2 = 1; src_b_s2 = 0; settle();
      chk("R10", "stall", bubble_s3, 1'b1);

      // mixed random snapshots over a small register range
      for (int n = 0; n < 3000; n++) begin
         cls_s2 = 3'($urandom % 7); cls_s3 = 3'($urandom % 7);
         cls_s4 = 3'($urandom % 7); cls_s5 = 3'($urandom % 7);
         src_b_s2 = AW'($urandom % 4); src_c_s2 = AW'($urandom % 4);
         dst_s3 = AW'($urandom % 4); src_b_s3 = AW'($urandom % 4);
         src_c_s3 = AW'($urandom % 4); dst_s4 = AW'($urandom % 4);
         dst_s5 = AW'($urandom % 4);
         imm_s2 = 1'($urandom); imm_s3 = 1'($urandom);
         opnd_x_s3 = $urandom; opnd_y_s3 = $urandom;
         res_s4 = $urandom; res_s5 = $urandom;
         settle();
         chk_all("R1");
      end

      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule